// File: doc/BRIEF.md
# ECC Strength Selector

This block picks the correction strength that an external NAND ECC engine will run with, given the geometry of one page. The ECC engine works on fixed 1 KiB data steps and offers four correction levels. The stronger levels need more spare bytes per step. The block takes the page size and the out-of-band (OOB) area size. It can also take a requested correction, given as a step size and a strength per step. From these it works out the per-step demand and the level to use.

The search runs in two phases, one table entry per clock. The first phase climbs from the weakest level until one meets the demand, stopping at the strongest level. When no demand is given, the search starts at the strongest level. The second phase walks down until the spare bytes of all steps fit in the OOB area. If no level fits, or the geometry is not supported, the block reports an error. Software pulses `start` and waits for the one-cycle `done`. It then reads the chosen level, its strength, the step count and a configuration word that carries the level in its type field.

Top module: `ecc_strength_sel`

## Requirements
- R1: After reset, `busy`, `done` and `error` are low, and `strength_idx`, `strength`, `step_count` and `cfg_word` are zero.
- R2: For a page of 2^`page_log2` bytes with `page_log2` from 11 to 14, `step_count` equals the page size divided by 1024 (2, 4, 8 or 16).
- R3: An OOB size below 64 bytes ends the search with `error` high.
- R4: A `page_log2` outside 11 to 14 ends the search with `error` high and `step_count` zero.
- R5: A demand exists when `req_step_log2` and `req_strength` are both non-zero and the product below is non-zero. The demand is ((page / 2^`req_step_log2`) × `req_strength`) / `step_count`, with every division truncated. The first candidate is the smallest level whose strength is at least this demand. Level 3 is used when none is large enough.
- R6: Without a demand, the first candidate is the strongest level, 3. This includes the case where the truncated product is zero.
- R7: The levels 0 to 3 have strengths 4, 8, 40 and 48 bits and spare sizes 32, 32, 96 and 96 bytes per step. From the first candidate, the level decreases until spare × `step_count` ≤ OOB size. That level is the result.
- R8: When even level 0 does not fit, `error` is high, and `strength_idx`, `strength` and `cfg_word` are zero.
- R9: On success, `cfg_word` bits 6:3 hold the level zero-extended to four bits. All other bits are zero, and `strength` is the level's strength.
- R10: `done` is a one-cycle pulse. A `start` seen while a search is in progress, or in the `done` cycle, is ignored. Results hold until the next accepted `start`.
- R11: `done` rises no more than 10 clock edges after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; inputs are captured on this edge |
| page_log2 | input | 4 | Page size as a power-of-two exponent |
| req_step_log2 | input | 5 | Requested step size exponent, 0 when absent |
| req_strength | input | 8 | Requested bits corrected per requested step, 0 when absent |
| oob_bytes | input | 12 | OOB area size in bytes |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| error | output | 1 | Geometry unsupported or nothing fits |
| strength_idx | output | 2 | Chosen level |
| strength | output | 6 | Bits corrected per 1 KiB step |
| step_count | output | 5 | Number of 1 KiB steps in the page |
| cfg_word | output | 32 | Configuration word with the level in bits 6:3 |

## Verification
The bench builds the block with its default parameters. These are page exponents 11 to 14, a 1 KiB step, a 64-byte OOB floor, a 12-bit OOB size and an 8-bit requested strength. With these values every level can be a result, both as a first candidate and after a walk-down. The clamp to the strongest level, a demand that truncates to zero, and a requested step larger than the page are all within reach. Both error paths, the geometry error and the no-fit error, can be driven from the ports. The 12-bit OOB field covers sizes that fit all sixteen strongest steps as well as sizes that fit none, and randomized geometries cover the space between the directed corners.

// File: rtl/ecc_sel_pkg.sv
package ecc_sel_pkg;

    localparam int NUM_LEVELS = 4;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int STR_OUT_W  = 6;
    localparam int SPARE_W    = 7;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_RISE,
        ST_FIT,
        ST_DONE
    } sel_state_e;

    typedef struct packed {
        logic geom_ok;
        logic oob_short;
        logic has_need;
    } demand_flags_t;

    // bits corrected per 1 KiB step for each level
    function automatic logic [STR_OUT_W-1:0] level_strength(lvl_t l);
        logic [STR_OUT_W-1:0] s;
        case (l)
            2'd0:    s = STR_OUT_W'(4);
            2'd1:    s = STR_OUT_W'(8);
            2'd2:    s = STR_OUT_W'(40);
            default: s = STR_OUT_W'(48);
        endcase
        return s;
    endfunction

    // spare bytes consumed per step for each level
    function automatic logic [SPARE_W-1:0] level_spare(lvl_t l);
        logic [SPARE_W-1:0] s;
        case (l)
            2'd0, 2'd1: s = SPARE_W'(32);
            default:    s = SPARE_W'(96);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ecc_sel_demand.sv
module ecc_sel_demand
    import ecc_sel_pkg::*;
#(
    parameter int PE_W          = 4,
    parameter int SE_W          = 5,
    parameter int RS_W          = 8,
    parameter int OOB_W         = 12,
    parameter int STEPS_W       = 5,
    parameter int NEED_W        = 24,
    parameter int STEP_LOG2     = 10,
    parameter int PAGE_LOG2_MIN = 11,
    parameter int PAGE_LOG2_MAX = 14,
    parameter int MIN_OOB       = 64
) (
    input  logic [PE_W-1:0]    page_log2,
    input  logic [SE_W-1:0]    step_log2,
    input  logic [RS_W-1:0]    strength_req,
    input  logic [OOB_W-1:0]   oob_bytes,
    output demand_flags_t      flags,
    output logic [STEPS_W-1:0] steps,
    output logic [NEED_W-1:0]  need
);

    localparam int PAGE_W = 1 << PE_W;
    localparam int PROD_W = PAGE_W + RS_W;

    logic [PAGE_W-1:0] page_bytes;
    logic [PAGE_W-1:0] units;
    logic [PROD_W-1:0] total;
    logic [PE_W-1:0]   step_shift;

    always_comb begin
        flags.geom_ok   = (page_log2 >= PE_W'(PAGE_LOG2_MIN)) &&
                          (page_log2 <= PE_W'(PAGE_LOG2_MAX));
        flags.oob_short = oob_bytes < OOB_W'(MIN_OOB);
        page_bytes      = PAGE_W'(1) << page_log2;
        // requested steps per page, truncated (zero when the step exceeds the page)
        units           = page_bytes >> step_log2;
        total           = PROD_W'(units) * PROD_W'(strength_req);
        flags.has_need  = (step_log2 != '0) && (strength_req != '0) && (total != '0);
        step_shift      = page_log2 - PE_W'(STEP_LOG2);
        steps           = flags.geom_ok ? (STEPS_W'(1) << step_shift) : '0;
        // per-step demand: divide by the step count, which is a power of two
        need            = NEED_W'(total >> step_shift);
    end

endmodule

// File: rtl/ecc_sel_levels.sv
module ecc_sel_levels
    import ecc_sel_pkg::*;
#(
    parameter int OOB_W   = 12,
    parameter int STEPS_W = 5,
    parameter int NEED_W  = 24
) (
    input  logic [STEPS_W-1:0]    steps,
    input  logic [OOB_W-1:0]      oob_bytes,
    input  logic [NEED_W-1:0]     need,
    output logic [NUM_LEVELS-1:0] meets,
    output logic [NUM_LEVELS-1:0] fits
);

    localparam int AREA_W = SPARE_W + STEPS_W;
    localparam int CMP_W  = (AREA_W > OOB_W) ? AREA_W : OOB_W;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        logic [AREA_W-1:0] area;
        assign area     = AREA_W'(level_spare(LVL_W'(g))) * AREA_W'(steps);
        assign fits[g]  = CMP_W'(area) <= CMP_W'(oob_bytes);
        assign meets[g] = NEED_W'(level_strength(LVL_W'(g))) >= need;
    end

endmodule

// File: rtl/ecc_sel_ctrl.sv
module ecc_sel_ctrl
    import ecc_sel_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  demand_flags_t         flags,
    input  logic [NUM_LEVELS-1:0] meets,
    input  logic [NUM_LEVELS-1:0] fits,
    output logic                  accept,
    output logic                  busy,
    output logic                  done,
    output lvl_t                  level,
    output logic                  ok,
    output logic                  err
);

    localparam lvl_t TOP_LVL = LVL_W'(NUM_LEVELS - 1);

    sel_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            level <= '0;
            ok    <= 1'b0;
            err   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_EVAL;
                        level <= '0;
                        ok    <= 1'b0;
                        err   <= 1'b0;
                    end
                end
                ST_EVAL: begin
                    if (!flags.geom_ok || flags.oob_short) begin
                        st  <= ST_DONE;
                        err <= 1'b1;
                    end else if (flags.has_need) begin
                        st    <= ST_RISE;
                        level <= '0;
                    end else begin
                        st    <= ST_FIT;
                        level <= TOP_LVL;
                    end
                end
                ST_RISE: begin
                    // climb until the demand is met or the strongest level is reached
                    if (meets[level] || level == TOP_LVL) st <= ST_FIT;
                    else                                  level <= level + 1'b1;
                end
                ST_FIT: begin
                    // descend until the spare area fits the OOB size
                    if (fits[level]) begin
                        st <= ST_DONE;
                        ok <= 1'b1;
                    end else if (level == '0) begin
                        st  <= ST_DONE;
                        err <= 1'b1;
                    end else begin
                        level <= level - 1'b1;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign accept = (st == ST_IDLE) && start;
    assign busy   = (st == ST_EVAL) || (st == ST_RISE) || (st == ST_FIT);
    assign done   = (st == ST_DONE);

endmodule

// File: rtl/ecc_strength_sel.sv
module ecc_strength_sel
    import ecc_sel_pkg::*;
#(
    parameter int PE_W          = 4,
    parameter int SE_W          = 5,
    parameter int RS_W          = 8,
    parameter int OOB_W         = 12,
    parameter int CFG_W         = 32,
    parameter int TYPE_LSB      = 3,
    parameter int TYPE_W        = 4,
    parameter int STEP_LOG2     = 10,
    parameter int PAGE_LOG2_MIN = 11,
    parameter int PAGE_LOG2_MAX = 14,
    parameter int MIN_OOB       = 64,
    localparam int STEPS_W      = PAGE_LOG2_MAX - STEP_LOG2 + 1,
    localparam int NEED_W       = (1 << PE_W) + RS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [PE_W-1:0]      page_log2,
    input  logic [SE_W-1:0]      req_step_log2,
    input  logic [RS_W-1:0]      req_strength,
    input  logic [OOB_W-1:0]     oob_bytes,
    output logic                 busy,
    output logic                 done,
    output logic                 error,
    output logic [LVL_W-1:0]     strength_idx,
    output logic [STR_OUT_W-1:0] strength,
    output logic [STEPS_W-1:0]   step_count,
    output logic [CFG_W-1:0]     cfg_word
);

    logic [PE_W-1:0]  pe_q;
    logic [SE_W-1:0]  se_q;
    logic [RS_W-1:0]  rs_q;
    logic [OOB_W-1:0] oob_q;

    demand_flags_t         flags;
    logic [STEPS_W-1:0]    steps;
    logic [NEED_W-1:0]     need;
    logic [NUM_LEVELS-1:0] meets;
    logic [NUM_LEVELS-1:0] fits;
    logic                  accept;
    lvl_t                  level;
    logic                  ok;
    logic                  err;

    always_ff @(posedge clk) begin
        if (rst) begin
            pe_q  <= '0;
            se_q  <= '0;
            rs_q  <= '0;
            oob_q <= '0;
        end else if (accept) begin
            pe_q  <= page_log2;
            se_q  <= req_step_log2;
            rs_q  <= req_strength;
            oob_q <= oob_bytes;
        end
    end

    ecc_sel_demand #(
        .PE_W(PE_W), .SE_W(SE_W), .RS_W(RS_W), .OOB_W(OOB_W),
        .STEPS_W(STEPS_W), .NEED_W(NEED_W), .STEP_LOG2(STEP_LOG2),
        .PAGE_LOG2_MIN(PAGE_LOG2_MIN), .PAGE_LOG2_MAX(PAGE_LOG2_MAX),
        .MIN_OOB(MIN_OOB)
    ) u_demand (
        .page_log2   (pe_q),
        .step_log2   (se_q),
        .strength_req(rs_q),
        .oob_bytes   (oob_q),
        .flags       (flags),
        .steps       (steps),
        .need        (need)
    );

    ecc_sel_levels #(
        .OOB_W(OOB_W), .STEPS_W(STEPS_W), .NEED_W(NEED_W)
    ) u_levels (
        .steps    (steps),
        .oob_bytes(oob_q),
        .need     (need),
        .meets    (meets),
        .fits     (fits)
    );

    ecc_sel_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .flags (flags),
        .meets (meets),
        .fits  (fits),
        .accept(accept),
        .busy  (busy),
        .done  (done),
        .level (level),
        .ok    (ok),
        .err   (err)
    );

    always_comb begin
        error        = err;
        step_count   = steps;
        strength_idx = ok ? level : '0;
        strength     = ok ? level_strength(level) : '0;
        cfg_word     = ok ? (CFG_W'(TYPE_W'(level)) << TYPE_LSB) : '0;
    end

endmodule

// File: rtl/ecc_strength_sel_chk.sv
module ecc_strength_sel_chk #(
    parameter int CFG_W    = 32,
    parameter int TYPE_LSB = 3,
    parameter int TYPE_W   = 4,
    parameter int OOB_W    = 12,
    parameter int STEPS_W  = 5,
    parameter int MIN_OOB  = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               error,
    input logic [5:0]         strength,
    input logic [STEPS_W-1:0] step_count,
    input logic [CFG_W-1:0]   cfg_word,
    input logic [OOB_W-1:0]   oob_q
);

    localparam logic [CFG_W-1:0] FIELD_MASK = CFG_W'((1 << TYPE_W) - 1) << TYPE_LSB;

    logic [TYPE_W-1:0] exp_code;
    logic [15:0]       spare_need;
    logic [3:0]        busy_run;

    always_comb begin
        case (strength)
            6'd4:    exp_code = TYPE_W'(0);
            6'd8:    exp_code = TYPE_W'(1);
            6'd40:   exp_code = TYPE_W'(2);
            6'd48:   exp_code = TYPE_W'(3);
            default: exp_code = '1;
        endcase
        spare_need = ((strength >= 6'd40) ? 16'd96 : 16'd32) * 16'(step_count);
    end

    always_ff @(posedge clk) begin
        if (rst)                  busy_run <= '0;
        else if (!busy)           busy_run <= '0;
        else if (busy_run != '1)  busy_run <= busy_run + 1'b1;
    end

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> (busy || done));

    a_r11_latency: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run <= 4'd8));

    a_r3_short_oob: assert property (@(posedge clk) disable iff (rst)
        (done && (oob_q < OOB_W'(MIN_OOB))) |-> error);

    a_r2_steps_pow2: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> $onehot(step_count));

    a_r7_spare_fits: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> (spare_need <= 16'(oob_q)));

    a_r8_error_zeroed: assert property (@(posedge clk) disable iff (rst)
        (done && error) |-> ((strength == '0) && (cfg_word == '0)));

    a_r9_type_field: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> ((cfg_word[TYPE_LSB +: TYPE_W] == exp_code) &&
                              ((cfg_word & ~FIELD_MASK) == '0)));

endmodule

bind ecc_strength_sel ecc_strength_sel_chk #(
    .CFG_W(CFG_W), .TYPE_LSB(TYPE_LSB), .TYPE_W(TYPE_W),
    .OOB_W(OOB_W), .STEPS_W(STEPS_W), .MIN_OOB(MIN_OOB)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .strength  (strength),
    .step_count(step_count),
    .cfg_word  (cfg_word),
    .oob_q     (oob_q)
);

// File: tb/ecc_strength_sel_bench.sv
module ecc_strength_sel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  page_log2 = '0;
    logic [4:0]  req_step_log2 = '0;
    logic [7:0]  req_strength = '0;
    logic [11:0] oob_bytes = '0;
    logic        busy, done, error;
    logic [1:0]  strength_idx;
    logic [5:0]  strength;
    logic [4:0]  step_count;
    logic [31:0] cfg_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic        err;
        logic [1:0]  lvl;
        logic [5:0]  str;
        logic [4:0]  steps;
        logic [31:0] cfg;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  mon_e;
    string mon_t;

    always #2 clk = ~clk;

    ecc_strength_sel u_ecc_strength_sel (
        .clk(clk), .rst(rst), .start(start),
        .page_log2(page_log2), .req_step_log2(req_step_log2),
        .req_strength(req_strength), .oob_bytes(oob_bytes),
        .busy(busy), .done(done), .error(error),
        .strength_idx(strength_idx), .strength(strength),
        .step_count(step_count), .cfg_word(cfg_word)
    );

    task automatic check(input bit cond, input string msg);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // independent model of the selection rules
    function automatic exp_t model(input int pe, input int se, input int rs, input int oob);
        exp_t e;
        int strs[4] = '{4, 8, 40, 48};
        int spr[4]  = '{32, 32, 96, 96};
        int steps, total, need, lvl;
        e = '0;
        steps = (pe >= 11 && pe <= 14) ? (1 << (pe - 10)) : 0;
        e.steps = 5'(steps);
        if (steps == 0 || oob < 64) begin
            e.err = 1'b1;
            return e;
        end
        if (se == 0 || rs == 0 || se > pe) total = 0;
        else                                total = (1 << (pe - se)) * rs;
        need = total / steps;
        if (total != 0) begin
            lvl = 0;
            while (lvl < 3 && strs[lvl] < need) lvl++;
        end else begin
            lvl = 3;
        end
        while (lvl >= 0 && spr[lvl] * steps > oob) lvl--;
        if (lvl < 0) begin
            e.err = 1'b1;
        end else begin
            e.lvl = 2'(lvl);
            e.str = 6'(strs[lvl]);
            e.cfg = 32'(lvl) << 3;
        end
        return e;
    endfunction

    // monitor: compare each result strobe against the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10: unexpected done, actual 1 expected 0");
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check({error, strength_idx, strength, step_count, cfg_word} ===
                      {mon_e.err, mon_e.lvl, mon_e.str, mon_e.steps, mon_e.cfg},
                      $sformatf("%s: actual err=%0d idx=%0d str=%0d steps=%0d cfg=%h expected err=%0d idx=%0d str=%0d steps=%0d cfg=%h",
                                mon_t, error, strength_idx, strength, step_count, cfg_word,
                                mon_e.err, mon_e.lvl, mon_e.str, mon_e.steps, mon_e.cfg));
            end
        end
    end

    // driver: apply one request, push expectation, check timing of done
    task automatic run_case(input int pe, input int se, input int rs, input int oob,
                            input string tag, input bit poke);
        int n;
        @(negedge clk);
        page_log2     = 4'(pe);
        req_step_log2 = 5'(se);
        req_strength  = 8'(rs);
        oob_bytes     = 12'(oob);
        start         = 1'b1;
        exp_q.push_back(model(pe, se, rs, oob));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        if (poke) begin
            // R10: a second start while busy must be ignored
            page_log2     = 4'd14;
            req_step_log2 = 5'd10;
            req_strength  = 8'd4;
            oob_bytes     = 12'd2000;
            start         = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n <= 10, $sformatf("R11 %s: latency actual %0d expected <= 10", tag, n));
        @(negedge clk);
        check(!done, $sformatf("R10 %s: done width, actual done=%0d expected 0", tag, done));
        if (poke) begin
            bit seen = 1'b0;
            for (int k = 0; k < 12; k++) begin
                if (done) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, $sformatf("R10 ignored start: actual extra done=%0d expected 0", seen));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check({busy, done, error, strength_idx, strength, step_count, cfg_word} == '0,
              $sformatf("R1: actual busy=%0d done=%0d err=%0d str=%0d steps=%0d cfg=%h expected all 0",
                        busy, done, error, strength, step_count, cfg_word));

        run_case(11, 0, 0, 64, "R6 no demand walks to level 1", 1'b0);
        run_case(13, 0, 0, 1024, "R6 no demand keeps level 3", 1'b0);
        run_case(12, 9, 8, 256, "R5 demand 16 then R7 walk-down", 1'b0);
        run_case(14, 10, 40, 1664, "R9 level 2 type field", 1'b0);
        run_case(11, 10, 1, 64, "R5 demand 1 picks level 0", 1'b0);
        run_case(12, 10, 8, 512, "R5 demand equal to strength 8", 1'b0);
        run_case(12, 10, 9, 512, "R5 demand 9 rounds up to 40", 1'b0);
        run_case(11, 9, 200, 224, "R5 clamp to strongest", 1'b0);
        run_case(12, 15, 8, 400, "R6 truncated product is zero", 1'b0);
        run_case(12, 9, 0, 400, "R6 zero strength means no demand", 1'b0);
        run_case(12, 10, 4, 63, "R3 OOB below floor", 1'b0);
        run_case(10, 10, 4, 512, "R4 page too small", 1'b0);
        run_case(15, 10, 4, 2048, "R4 page too large", 1'b0);
        run_case(11, 0, 0, 32 + 31, "R3 OOB 63 no demand", 1'b0);
        run_case(12, 0, 0, 100, "R8 nothing fits", 1'b0);
        run_case(14, 0, 0, 1536, "R2 sixteen steps", 1'b0);
        run_case(11, 0, 0, 64, "R10 ignored start", 1'b1);

        for (int i = 0; i < 60; i++) begin
            run_case(10 + int'($urandom_range(5)), int'($urandom_range(15)),
                     int'($urandom_range(63)), int'($urandom_range(2047)),
                     "R7 random geometry", 1'b0);
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0,
              $sformatf("R10 pending results: actual %0d expected 0", exp_q.size()));
        report();
    end

endmodule